// File: doc/BRIEF.md
# Seconds-Counter Alarm with Interrupt Control

This block watches a free-running 48-bit seconds count supplied from outside and compares it with a programmable 48-bit alarm time. When the two are equal it latches an event flag. A second event source, an external single-cycle pulse, latches its own flag next to the alarm flag. Each flag can be gated into one level-high interrupt line by a per-source enable.

Software programs the alarm time as a 32-bit low word and a 16-bit high word. It reads the latched flags either raw or gated by the enables, and it clears a flag by writing 1 to its bit. Enables are never written directly. One register turns sources on and a separate register turns them off, so two agents can each change their own source without a read-modify-write race.

Flag bit 0 is always the alarm and bit 1 is always the external event, in every status and enable register.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the alarm time reads all ones (low word 0xFFFFFFFF, high word 0x0000FFFF), and the raw flags, the gated flags, the enables and `irq` are all 0.
- R2: Byte offset 0x00 holds alarm bits 31:0 and offset 0x04 holds alarm bits 47:32. A write to 0x04 keeps only `bus_wdata[15:0]`, and a read of 0x04 returns zeros above bit 15.
- R3: In any cycle in which `sec_count` equals the 48-bit alarm time, raw flag bit 0 is set on the following clock edge and stays set until it is cleared.
- R4: A high level on `alt_evt` at a clock edge sets raw flag bit 1 on that edge.
- R5: Offset 0x08 reads the raw flags in bits 1:0. Offset 0x0C reads each raw flag ANDed with its enable.
- R6: Writing 1 to bit n at offset 0x10 sets enable n. Writing 0 leaves it unchanged. Offsets 0x10 and 0x14 both read back the current enables in bits 1:0.
- R7: Writing 1 to bit n at offset 0x14 clears enable n. Writing 0 leaves it unchanged.
- R8: Writing 1 to bit n at offset 0x0C clears raw flag n. Writing 0 has no effect. A flag never drops without such a write.
- R9: If a clear of flag n and a new event on source n fall on the same clock edge, the flag ends up set.
- R10: `irq` is high exactly while at least one raw flag and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sec_count | input | 48 | Current seconds count |
| alt_evt | input | 1 | External event pulse |
| irq | output | 1 | Level-high interrupt |

## Verification
The hardest case to reach is a clear of a flag landing on the same edge as a new event for that flag. The bench reaches it by driving `alt_evt` in the very cycle of a clear write to bit 1. A second hard case is an alarm match across the carry from the low word into the high word. For that, the count is preloaded just below a 2^32 boundary with the alarm set just above it, and then counted through. A further phase pulses the external event at random and moves enables in both directions while the count runs. A reference model checks `irq` on every clock throughout.

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  sec_count,
  input  logic              alt_evt,
  output logic              irq
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam int NSRC = 2;
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'('h14);

  logic [DATA_W-1:0] cmp_lo;
  logic [HI_W-1:0]   cmp_hi;
  logic [NSRC-1:0]   raw_q, en_q, hit, wipe, gated;

  assign hit   = {alt_evt, sec_count == {cmp_hi, cmp_lo}};
  assign wipe  = (bus_we && bus_addr == A_STS) ? bus_wdata[NSRC-1:0] : '0;
  assign gated = raw_q & en_q;
  assign irq   = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_lo <= '1;
      cmp_hi <= '1;
      raw_q  <= '0;
      en_q   <= '0;
    end else begin
      raw_q <= (raw_q & ~wipe) | hit;
      if (bus_we) begin
        case (bus_addr)
          A_LO:    cmp_lo <= bus_wdata;
          A_HI:    cmp_hi <= bus_wdata[HI_W-1:0];
          A_SET:   en_q   <= en_q | bus_wdata[NSRC-1:0];
          A_CLR:   en_q   <= en_q & ~bus_wdata[NSRC-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_LO:         bus_rdata = cmp_lo;
      A_HI:         bus_rdata = {{(DATA_W-HI_W){1'b0}}, cmp_hi};
      A_RAW:        bus_rdata = {{(DATA_W-NSRC){1'b0}}, raw_q};
      A_STS:        bus_rdata = {{(DATA_W-NSRC){1'b0}}, gated};
      A_SET, A_CLR: bus_rdata = {{(DATA_W-NSRC){1'b0}}, en_q};
      default:      bus_rdata = '0;
    endcase
  end

  p_match_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_count == {cmp_hi, cmp_lo}) |=> raw_q[0]);
  p_alt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alt_evt |=> raw_q[1]);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_evt && bus_we && bus_addr == A_STS && bus_wdata[1]) |=> raw_q[1]);
  p_en_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET && bus_wdata[0]) |=> en_q[0]);
  p_en_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR && bus_wdata[0]) |=> !en_q[0]);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_STS) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
endmodule

// File: tb/sim_rtc_alarm_irq.sv
`timescale 1ns/1ps
module sim_rtc_alarm_irq;
  logic        clk = 0, rst_n = 0, bus_we = 0, alt_evt = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [47:0] sec_count = 48'h10;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  logic [47:0] m_cmp;
  logic [1:0]  m_raw, m_en;

  always #2.5 clk = ~clk;

  rtc_alarm_irq u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_count(sec_count),
    .alt_evt(alt_evt), .irq(irq));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmp <= '1; m_raw <= 0; m_en <= 0;
    end else begin
      logic [1:0] nr;
      nr = m_raw;
      if (bus_we && bus_addr == 5'h0C) nr = nr & ~bus_wdata[1:0];
      if (sec_count == m_cmp) nr[0] = 1'b1;
      if (alt_evt) nr[1] = 1'b1;
      m_raw <= nr;
      if (bus_we) begin
        if (bus_addr == 5'h00) m_cmp[31:0] <= bus_wdata;
        if (bus_addr == 5'h04) m_cmp[47:32] <= bus_wdata[15:0];
        if (bus_addr == 5'h10) m_en <= m_en | bus_wdata[1:0];
        if (bus_addr == 5'h14) m_en <= m_en & ~bus_wdata[1:0];
      end
    end
  end

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a)
      5'h00: return m_cmp[31:0];
      5'h04: return {16'h0, m_cmp[47:32]};
      5'h08: return {30'h0, m_raw};
      5'h0C: return {30'h0, m_raw & m_en};
      5'h10, 5'h14: return {30'h0, m_en};
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R10: irq compared against the model every cycle
  always @(negedge clk) if (rst_n && !done) check("R10 irq", {31'h0, irq}, {31'h0, |(m_raw & m_en)});

  task automatic wr(logic [4:0] a, logic [31:0] d, logic alt = 0);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d; alt_evt = alt;
    @(negedge clk);
    bus_we = 0; alt_evt = 0;
  endtask

  task automatic rd(string tag, logic [4:0] a);
    @(negedge clk);
    bus_addr = a;
    #1 check(tag, bus_rdata, m_read(a));
  endtask

  task automatic rd_lit(string tag, logic [4:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(tag, bus_rdata, exp);
  endtask

  task automatic run(int n, bit rnd = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sec_count = sec_count + 1;
      alt_evt = rnd ? ($urandom_range(0, 7) == 0) : 1'b0;
    end
    @(negedge clk);
    alt_evt = 0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_lit("R1 cmp lo", 5'h00, 32'hFFFF_FFFF);
    rd_lit("R1 cmp hi", 5'h04, 32'h0000_FFFF);
    rd_lit("R1 raw", 5'h08, 0);
    rd_lit("R1 sts", 5'h0C, 0);
    rd_lit("R1 en", 5'h10, 0);
    check("R1 irq", {31'h0, irq}, 0);

    wr(5'h00, 32'h1234_5678);
    wr(5'h04, 32'h000A_BCD5);
    rd_lit("R2 lo", 5'h00, 32'h1234_5678);
    rd_lit("R2 hi", 5'h04, 32'h0000_BCD5);

    wr(5'h04, 0);
    wr(5'h00, 32'(sec_count + 6));
    run(4);
    rd_lit("R3 before match", 5'h08, 0);
    run(4);
    rd_lit("R3 after match", 5'h08, 32'h1);
    rd_lit("R5 gated off", 5'h0C, 0);

    wr(5'h10, 32'h1);
    rd_lit("R6 en set", 5'h10, 32'h1);
    rd_lit("R5 gated on", 5'h0C, 32'h1);
    check("R10 irq up", {31'h0, irq}, 1);
    wr(5'h10, 0);
    rd_lit("R6 zero write", 5'h14, 32'h1);

    wr(5'h0C, 0);
    rd_lit("R8 zero write", 5'h08, 32'h1);
    wr(5'h0C, 32'h1);
    rd_lit("R8 clear", 5'h08, 0);
    check("R10 irq down", {31'h0, irq}, 0);

    @(negedge clk); alt_evt = 1; @(negedge clk); alt_evt = 0;
    rd_lit("R4 alt", 5'h08, 32'h2);
    wr(5'h10, 32'h2);
    rd_lit("R5 alt gated", 5'h0C, 32'h2);
    wr(5'h0C, 32'h2, 1'b1);
    rd_lit("R9 set wins", 5'h08, 32'h2);
    wr(5'h0C, 32'h2);
    rd_lit("R9 later clear", 5'h08, 0);

    wr(5'h14, 0);
    rd_lit("R7 zero write", 5'h10, 32'h3);
    wr(5'h14, 32'h1);
    rd_lit("R7 clear", 5'h10, 32'h2);

    @(negedge clk); sec_count = 48'h1_FFFF_FFF0;
    wr(5'h00, 32'h0000_0002);
    wr(5'h04, 32'h2);
    wr(5'h10, 32'h1);
    run(10);
    rd_lit("R3 before carry", 5'h08, 0);
    run(10);
    rd_lit("R3 across carry", 5'h08, 32'h1);

    for (int k = 0; k < 20; k++) begin
      wr(5'h00, 32'(sec_count + 3));
      wr(5'h04, 32'(sec_count >> 32));
      run(8, 1);
      rd("R5 random raw", 5'h08);
      rd("R5 random gated", 5'h0C);
      wr($urandom_range(0, 1) ? 5'h10 : 5'h14, $urandom_range(0, 3));
      rd("R6 R7 random en", 5'h10);
      wr(5'h0C, $urandom_range(0, 3), $urandom_range(0, 1));
      rd("R8 R9 random clear", 5'h08);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule